// File: doc/BRIEF.md
# Floppy Write Serializer

This block turns bytes from a host into a serial bit stream on a floppy drive's write line. It also tracks which of three shift modes the controller is in. The host presents bytes on a valid/ready input. The block holds them in two places: an active shift register and a one-byte pending register. While the block is writing, it sends one bit per bit cell, most significant bit first, and refills the shift register from the pending register at each byte boundary. If nothing is pending when a byte finishes, the block flags an underrun, stops writing and pulses the drive's end-of-write strobe.

Two select inputs choose the mode: read, write-protect sense or write. Write mode can only be entered from sense mode. The drive sees a one-cycle begin strobe when writing starts and a one-cycle end strobe when it stops. A handshake byte shows whether the pending register is free and whether an underrun has occurred. A status byte combines a five-bit configuration field, the enable input and the drive's sense line.

Back-pressure works as follows. A byte moves on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low when the pending register is occupied. It is also low during the cell tick that closes a byte and during the cycle in which write mode is left. Data on the input has no effect while `in_ready` is low.

Top module: `floppy_write_serializer`

## Requirements
- R1: After a synchronous active-high reset, the block is in the following state:
  - the mode is read (`shift_mode_o` = 0);
  - `handshake_o` = 0xC0;
  - `in_ready` = 1;
  - the bit count is zero;
  - all strobes are low.
- R2: The mode is computed on every clock edge from {`write_sel_i`, `latch_sel_i`}. The mode encoding is read=0, sense=1, write=2.
  - 00 selects read.
  - 10 selects write only when the current mode is sense; otherwise the mode is kept.
  - 01 and 11 select sense.
- R3: On the edge that enters write mode, `wr_begin_o` goes high for exactly one cycle and streaming starts.
- R4: On the edge that leaves write mode, `handshake_o` returns to 0xC0 and any partial byte is discarded (the bit count is cleared). `wr_end_o` pulses for one cycle only if streaming was still active.
- R5: The bit period L is `cell_len_i` in cycles, with a value of 0 treated as 1. The first cell pulse comes L cycles after the begin strobe, and later pulses follow every L cycles. `wr_bit_o` changes only together with a `wr_cell_o` pulse and holds its value for the rest of the cell.
- R6: Each cell sends the shift register's most significant bit, and the register then shifts left by one. Bytes go out in the order they were accepted. No cell pulse occurs when no accepted bit is left.
- R7: When the eighth bit of a byte goes out and the pending register is occupied, the pending byte moves into the shift register on that same edge. Handshake bit 7 is then set, so `in_ready` rises.
- R8: When a byte ends (or a cell ticks with a count of zero) and nothing is pending, the following happens on that edge:
  - handshake bit 6 clears, giving 0x80;
  - `wr_end_o` pulses in the same cycle as the last cell pulse (if any);
  - streaming stops, and the mode stays write.
- R9: An accepted byte loads the shift register directly, with a count of eight, when handshake bit 7 is set and the bit count is zero. Otherwise the byte goes to the pending register and bit 7 clears.
- R10: The bits of `status_o` are assigned as follows:
  - `status_o[4:0]` = `cfg_bits_i`;
  - bit 5 = `enable_i`;
  - bit 6 = 0;
  - bit 7 = the sense line, which reads 1 when `drive_present_i` is low and `drive_sense_i` otherwise.
- R11: Bits 5..0 of `handshake_o` always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| write_sel_i | input | 1 | Mode select, upper bit |
| latch_sel_i | input | 1 | Mode select, lower bit |
| enable_i | input | 1 | Controller enable, reported in status |
| cfg_bits_i | input | 5 | Configuration field reported in status |
| cell_len_i | input | 6 | Bit cell length in clock cycles (0 means 1) |
| drive_present_i | input | 1 | A drive is attached |
| drive_sense_i | input | 1 | Drive sense line |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Block can take a byte this cycle |
| shift_mode_o | output | 2 | Current mode: 0 read, 1 sense, 2 write |
| status_o | output | 8 | Status byte |
| handshake_o | output | 8 | Handshake byte: bit 7 pending free, bit 6 no underrun |
| wr_bit_o | output | 1 | Serial write data, held for a whole cell |
| wr_cell_o | output | 1 | One-cycle pulse when a new bit is placed on wr_bit_o |
| wr_begin_o | output | 1 | One-cycle begin-of-write strobe |
| wr_end_o | output | 1 | One-cycle end-of-write strobe |

## Verification
The bench targets several corner cases:
- Refill at the byte boundary: a design that refilled one cell late would still show eight bits of the old byte when `in_ready` rises.
- Final byte of a stream: an underrun raised at the wrong moment would either drop the final bit or let stray cell pulses follow the end strobe.
- Write entry with no data loaded, and entry attempted directly from read: a design that ignored the sense-first rule would enter write mode and pulse begin.
- Leaving write mode in the middle of a byte with a one-cycle cell: this must produce exactly one end strobe and restore the handshake byte. Leaving again after an underrun must produce no second strobe.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [1:0] {
    SM_READ  = 2'd0,
    SM_SENSE = 2'd1,
    SM_WRITE = 2'd2
  } shift_mode_e;

  localparam int HS_W   = 8;
  localparam int STAT_W = 8;
  localparam int CFG_W  = 5;

endpackage

// File: rtl/fws_mode_ctl.sv
module fws_mode_ctl
  import fws_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        write_sel_i,
  input  logic        latch_sel_i,
  output shift_mode_e mode_o,
  output logic        enter_o,
  output logic        leave_o,
  output logic        begin_o
);

  shift_mode_e mode_q;
  shift_mode_e mode_d;
  logic        begin_q;

  always_comb begin
    mode_d = mode_q;
    unique case ({write_sel_i, latch_sel_i})
      2'b00: mode_d = SM_READ;
      2'b10: if (mode_q == SM_SENSE) mode_d = SM_WRITE;
      default: mode_d = SM_SENSE;
    endcase
  end

  assign enter_o = (mode_d == SM_WRITE) && (mode_q != SM_WRITE);
  assign leave_o = (mode_d != SM_WRITE) && (mode_q == SM_WRITE);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= SM_READ;
      begin_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      begin_q <= enter_o;
    end
  end

  assign mode_o  = mode_q;
  assign begin_o = begin_q;

  AST_WRITE_FROM_SENSE: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_q == SM_WRITE) |-> $past(mode_q) == SM_SENSE);  // R2

  AST_BEGIN_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    begin_q |-> (mode_q == SM_WRITE) && !$past(begin_q));  // R3

endmodule

// File: rtl/fws_cell_timer.sv
module fws_cell_timer #(
  parameter int CELL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              run_i,
  input  logic [CELL_W-1:0] len_i,
  output logic              tick_o
);

  logic [CELL_W-1:0] cnt_q;
  logic [CELL_W-1:0] reload;

  assign reload = (len_i == '0) ? '0 : len_i - 1'b1;
  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload;
    end else if (run_i) begin
      if (cnt_q == '0) cnt_q <= reload;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick_o && reload != '0 && !load_i) |=> !tick_o);  // R5

endmodule

// File: rtl/fws_shifter.sv
module fws_shifter
  import fws_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enter_i,
  input  logic              leave_i,
  input  logic              tick_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [HS_W-1:0]   handshake_o,
  output logic              wr_bit_o,
  output logic              wr_cell_o,
  output logic              wr_end_o,
  output logic              streaming_o
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] pend_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              hs_free_q;
  logic              hs_ok_q;
  logic              streaming_q;
  logic              bit_q;
  logic              cell_q;
  logic              end_q;
  logic              byte_end;
  logic              accept;

  assign byte_end = tick_i && (cnt_q <= ONE_CNT);
  assign in_ready = hs_free_q && !byte_end && !leave_i;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q        <= '0;
      pend_q      <= '0;
      cnt_q       <= '0;
      hs_free_q   <= 1'b1;
      hs_ok_q     <= 1'b1;
      streaming_q <= 1'b0;
      bit_q       <= 1'b0;
      cell_q      <= 1'b0;
      end_q       <= 1'b0;
    end else begin
      cell_q <= 1'b0;
      end_q  <= 1'b0;
      if (leave_i) begin
        hs_free_q   <= 1'b1;
        hs_ok_q     <= 1'b1;
        streaming_q <= 1'b0;
        cnt_q       <= '0;
        end_q       <= streaming_q;
      end else begin
        if (enter_i) streaming_q <= 1'b1;
        if (tick_i) begin
          if (cnt_q != '0) begin
            bit_q  <= sr_q[DATA_W-1];
            sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
            cnt_q  <= cnt_q - 1'b1;
            cell_q <= 1'b1;
          end
          if (byte_end) begin
            if (!hs_free_q) begin
              sr_q      <= pend_q;
              cnt_q     <= FULL_CNT;
              hs_free_q <= 1'b1;
            end else begin
              hs_ok_q     <= 1'b0;
              streaming_q <= 1'b0;
              end_q       <= 1'b1;
            end
          end
        end
        if (accept) begin
          if (cnt_q == '0) begin
            sr_q  <= in_data;
            cnt_q <= FULL_CNT;
          end else begin
            pend_q    <= in_data;
            hs_free_q <= 1'b0;
          end
        end
      end
    end
  end

  assign handshake_o = {hs_free_q, hs_ok_q, {(HS_W-2){1'b0}}};
  assign wr_bit_o    = bit_q;
  assign wr_cell_o   = cell_q;
  assign wr_end_o    = end_q;
  assign streaming_o = streaming_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);  // R6

  AST_UNDERRUN_ENDS: assert property (@(posedge clk) disable iff (rst)
    (tick_i && cnt_q <= ONE_CNT && hs_free_q && !leave_i) |=> (end_q && !streaming_q && !hs_ok_q));  // R8

  AST_LEAVE_RESTORES: assert property (@(posedge clk) disable iff (rst)
    leave_i |=> (hs_free_q && hs_ok_q && cnt_q == '0 && !streaming_q));  // R4

  AST_REFILL_FREES: assert property (@(posedge clk) disable iff (rst)
    (byte_end && !hs_free_q && !leave_i) |=> (hs_free_q && cnt_q == FULL_CNT));  // R7

endmodule

// File: rtl/floppy_write_serializer.sv
module floppy_write_serializer
  import fws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CELL_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              write_sel_i,
  input  logic              latch_sel_i,
  input  logic              enable_i,
  input  logic [CFG_W-1:0]  cfg_bits_i,
  input  logic [CELL_W-1:0] cell_len_i,
  input  logic              drive_present_i,
  input  logic              drive_sense_i,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [1:0]        shift_mode_o,
  output logic [STAT_W-1:0] status_o,
  output logic [HS_W-1:0]   handshake_o,
  output logic              wr_bit_o,
  output logic              wr_cell_o,
  output logic              wr_begin_o,
  output logic              wr_end_o
);

  shift_mode_e mode;
  logic        enter;
  logic        leave;
  logic        tick;
  logic        streaming;
  logic        run;
  logic        sense;

  fws_mode_ctl u_mode (
    .clk         (clk),
    .rst         (rst),
    .write_sel_i (write_sel_i),
    .latch_sel_i (latch_sel_i),
    .mode_o      (mode),
    .enter_o     (enter),
    .leave_o     (leave),
    .begin_o     (wr_begin_o)
  );

  assign run = (mode == SM_WRITE) && streaming;

  fws_cell_timer #(.CELL_W(CELL_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load_i (enter),
    .run_i  (run),
    .len_i  (cell_len_i),
    .tick_o (tick)
  );

  fws_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .enter_i     (enter),
    .leave_i     (leave),
    .tick_i      (tick),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .handshake_o (handshake_o),
    .wr_bit_o    (wr_bit_o),
    .wr_cell_o   (wr_cell_o),
    .wr_end_o    (wr_end_o),
    .streaming_o (streaming)
  );

  assign sense        = drive_present_i ? drive_sense_i : 1'b1;
  assign status_o     = {sense, 1'b0, enable_i, cfg_bits_i};
  assign shift_mode_o = mode;

  AST_CELL_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_cell_o |-> $past(mode) == SM_WRITE);  // R5

  AST_HS_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    handshake_o[HS_W-3:0] == '0);  // R11

endmodule

// File: tb/sim_floppy_write_serializer.sv
module sim_floppy_write_serializer;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       write_sel_i = 1'b0;
  logic       latch_sel_i = 1'b0;
  logic       enable_i = 1'b0;
  logic [4:0] cfg_bits_i = '0;
  logic [5:0] cell_len_i = 6'd4;
  logic       drive_present_i = 1'b0;
  logic       drive_sense_i = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic [1:0] shift_mode_o;
  logic [7:0] status_o;
  logic [7:0] handshake_o;
  logic       wr_bit_o;
  logic       wr_cell_o;
  logic       wr_begin_o;
  logic       wr_end_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_len = 4;
  int last_evt = 0;
  int begin_cyc = 0;
  int end_cyc = 0;
  int end_cnt = 0;
  int end_qsize = 0;
  bit end_with_cell = 1'b0;
  bit exp_bits[$];

  floppy_write_serializer u0 (
    .clk(clk), .rst(rst), .write_sel_i(write_sel_i), .latch_sel_i(latch_sel_i),
    .enable_i(enable_i), .cfg_bits_i(cfg_bits_i), .cell_len_i(cell_len_i),
    .drive_present_i(drive_present_i), .drive_sense_i(drive_sense_i),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .shift_mode_o(shift_mode_o), .status_o(status_o), .handshake_o(handshake_o),
    .wr_bit_o(wr_bit_o), .wr_cell_o(wr_cell_o), .wr_begin_o(wr_begin_o), .wr_end_o(wr_end_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      report();
      $finish;
    end
  end

  // Monitor: pops the expected bit for every cell pulse and checks cell spacing.
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_begin_o) begin
        last_evt  = cyc;
        begin_cyc = cyc;
      end
      if (wr_cell_o) begin
        if (exp_bits.size() == 0) begin
          chk(1'b0, "R6 cell pulse with no bit left", 1, 0);
        end else begin
          bit e;
          e = exp_bits.pop_front();
          chk(wr_bit_o == e, "R6 serial bit", wr_bit_o, e);
        end
        chk((cyc - last_evt) == exp_len, "R5 cell spacing", cyc - last_evt, exp_len);
        last_evt = cyc;
      end
      if (wr_end_o) begin
        end_cnt++;
        end_cyc       = cyc;
        end_with_cell = wr_cell_o;
        end_qsize     = exp_bits.size();
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (!in_ready) step(1);
    in_valid = 1'b1;
    in_data  = b;
    for (int i = 7; i >= 0; i--) exp_bits.push_back(b[i]);
    step(1);
    in_valid = 1'b0;
  endtask

  task automatic set_sel(input logic w, input logic l);
    write_sel_i = w;
    latch_sel_i = l;
    step(1);
  endtask

  initial begin
    int prev;
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    chk(shift_mode_o == 2'd0, "R1 mode", shift_mode_o, 0);
    chk(handshake_o == 8'hC0, "R1 handshake", handshake_o, 8'hC0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(!wr_begin_o && !wr_end_o && !wr_cell_o, "R1 strobes", {wr_begin_o, wr_end_o, wr_cell_o}, 0);

    // R10 status layout
    chk(status_o == 8'h80, "R10 status no drive", status_o, 8'h80);
    cfg_bits_i = 5'h15; enable_i = 1'b1; #1;
    chk(status_o == 8'hB5, "R10 status cfg/enable", status_o, 8'hB5);
    drive_present_i = 1'b1; drive_sense_i = 1'b0; #1;
    chk(status_o == 8'h35, "R10 sense low", status_o, 8'h35);
    drive_sense_i = 1'b1; #1;
    chk(status_o == 8'hB5, "R10 sense high", status_o, 8'hB5);

    // R2 mode rules
    set_sel(1'b1, 1'b0); step(1);
    chk(shift_mode_o == 2'd0, "R2 write refused from read", shift_mode_o, 0);
    chk(end_cnt == 0, "R2 no strobe from read", end_cnt, 0);
    set_sel(1'b1, 1'b1);
    chk(shift_mode_o == 2'd1, "R2 11 gives sense", shift_mode_o, 1);
    set_sel(1'b0, 1'b0);
    chk(shift_mode_o == 2'd0, "R2 00 gives read", shift_mode_o, 0);
    set_sel(1'b0, 1'b1);
    chk(shift_mode_o == 2'd1, "R2 01 gives sense", shift_mode_o, 1);

    // R9 loading in sense mode
    exp_len = 4; cell_len_i = 6'd4;
    send_byte(8'hA5);
    chk(handshake_o == 8'hC0, "R9 direct load keeps bit7", handshake_o, 8'hC0);
    send_byte(8'h3C);
    chk(handshake_o == 8'h40, "R9 pending clears bit7", handshake_o, 8'h40);
    chk(in_ready == 1'b0, "R9 ready low when pending full", in_ready, 0);

    // R3 enter write
    set_sel(1'b1, 1'b0);
    chk(shift_mode_o == 2'd2, "R3 mode write", shift_mode_o, 2);
    chk(wr_begin_o == 1'b1, "R3 begin pulse", wr_begin_o, 1);
    step(1);
    chk(wr_begin_o == 1'b0, "R3 begin one cycle", wr_begin_o, 0);
    chk(shift_mode_o == 2'd2, "R2 10 holds write", shift_mode_o, 2);

    // R7 refill at byte boundary
    while (!in_ready) step(1);
    chk(exp_bits.size() == 8, "R7 refill at eighth bit", exp_bits.size(), 8);
    chk(handshake_o == 8'hC0, "R7 handshake after refill", handshake_o, 8'hC0);
    send_byte(8'hF0);

    // R8 underrun
    while (end_cnt < 1) step(1);
    chk(end_with_cell == 1'b1, "R8 end with last cell", end_with_cell, 1);
    chk(end_qsize == 0, "R8 all bits sent", end_qsize, 0);
    chk(handshake_o == 8'h80, "R8 underrun handshake", handshake_o, 8'h80);
    chk(shift_mode_o == 2'd2, "R8 mode stays write", shift_mode_o, 2);
    step(20);
    chk(end_cnt == 1, "R8 single end strobe", end_cnt, 1);

    // R4 leave after underrun: no second strobe
    set_sel(1'b0, 1'b0);
    chk(shift_mode_o == 2'd0, "R4 back to read", shift_mode_o, 0);
    chk(handshake_o == 8'hC0, "R4 handshake restored", handshake_o, 8'hC0);
    step(1);
    chk(end_cnt == 1, "R4 no strobe when not streaming", end_cnt, 1);

    // R5 cell length zero -> one cycle, R4 leave mid-byte
    cell_len_i = 6'd0; exp_len = 1;
    set_sel(1'b0, 1'b1);
    send_byte(8'hFF);
    send_byte(8'h00);
    set_sel(1'b1, 1'b0);
    chk(wr_begin_o == 1'b1, "R3 begin second entry", wr_begin_o, 1);
    step(4);
    prev = end_cnt;
    write_sel_i = 1'b0; latch_sel_i = 1'b0;
    step(1);
    chk(end_cnt == prev + 1, "R4 end strobe when leaving mid-byte", end_cnt, prev + 1);
    chk(wr_cell_o == 1'b0, "R4 no cell on leave", wr_cell_o, 0);
    chk(handshake_o == 8'hC0, "R4 handshake after leave", handshake_o, 8'hC0);
    chk(shift_mode_o == 2'd0, "R4 mode read", shift_mode_o, 0);
    exp_bits.delete();
    step(3);

    // R8 entry with no data: underrun after one cell, no bits
    cell_len_i = 6'd3; exp_len = 3;
    set_sel(1'b0, 1'b1);
    prev = end_cnt;
    set_sel(1'b1, 1'b0);
    while (end_cnt == prev) step(1);
    chk((end_cyc - begin_cyc) == 3, "R8 empty entry underrun timing", end_cyc - begin_cyc, 3);
    chk(end_with_cell == 1'b0, "R8 no cell when empty", end_with_cell, 0);
    chk(handshake_o == 8'h80, "R8 empty underrun handshake", handshake_o, 8'h80);
    chk(handshake_o[5:0] == 6'd0, "R11 low bits zero", handshake_o[5:0], 0);
    set_sel(1'b0, 1'b0);
    chk(handshake_o == 8'hC0, "R4 restore after empty run", handshake_o, 8'hC0);

    report();
    $finish;
  end

endmodule